// File: doc/BRIEF.md
# Shadow-PC Interrupt Entry Unit

This unit sits beside a CPU's fetch logic and owns the program counter and the user flags. It takes an interrupt without any memory vector read. At an instruction boundary with a pending, enabled and unmasked request, it loads the PC from a handler-address register. In the same cycle it saves the interrupted PC and flags into dedicated return registers and sets the mask.

Software controls the saved state through single-cycle instruction strobes. It can load the handler address, push and pull the return PC and return flags, enable or disable interrupts, and lift the mask. To allow nesting, a handler pushes the return registers before it unmasks. The return instruction restores the PC and flags from the return registers and clears the mask. Each strobe's effect shows on the registered outputs one clock later.

Top module: `shpc_top`

## Requirements
- R1: After synchronous reset, `pc_o`, `flags_o`, `push_o` and `ack_o` are zero, the handler address is zero, interrupts are disabled, the mask is clear and nothing is pending.
- R2: When `step_i` is high, a request is pending (or `irq_i` is high), interrupts are enabled and the mask is clear, the interrupt is taken. On the next cycle `pc_o` equals the handler address and `ack_o` is high for exactly one cycle.
- R3: On a taken interrupt the return-PC register captures `seq_pc_i`. The return-flags register captures the flags as updated in that same cycle.
- R4: Op code 6 (load handler) writes `data_i` into the handler-address register, and later interrupts jump to that value.
- R5: Op code 2 (push return PC) places the return PC on `push_o` on the next cycle. Op code 3 (push return flags) places the zero-extended return flags there. Op codes 4 and 5 load the return PC and return flags from `data_i`. `push_o` holds its value otherwise.
- R6: Op code 1 (return) loads `pc_o` from the return PC and `flags_o` from the return flags, and clears the mask.
- R7: Taking an interrupt sets the mask. While the mask is set, requests stay pending and are not taken. A pending request is taken at the first `step_i` after op code 9 (unmask) or op code 1 has cleared the mask.
- R8: Interrupts are disabled at reset. Op code 7 enables them and op code 8 disables them. A request that arrives while they are disabled stays pending.
- R9: If an interrupt is taken in the same cycle as op code 1, the interrupt wins. `pc_o` becomes the handler address, the return PC keeps its value as the return target, and the return flags keep theirs and are also loaded into `flags_o`.
- R10: With `step_i` high and no interrupt and no return, `pc_o` takes `seq_pc_i`. With `step_i` low and no return or interrupt, `pc_o` holds.
- R11: `flags_wr_i` loads `flags_d_i` into `flags_o` unless a return happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Instruction boundary strobe |
| seq_pc_i | input | PC_W | PC the core would run next |
| op_i | input | 4 | Instruction strobe code (0 means none) |
| data_i | input | PC_W | Data for pull/load operations |
| flags_wr_i | input | 1 | User flag write enable |
| flags_d_i | input | FLAG_W | User flag write value |
| irq_i | input | 1 | Interrupt request |
| pc_o | output | PC_W | Program counter |
| flags_o | output | FLAG_W | User flags |
| push_o | output | PC_W | Value to push for push operations |
| ack_o | output | 1 | One-cycle pulse after an interrupt is taken |

## Verification
The entry path is driven with a request that arrives while interrupts are disabled, which separates a held pending request from one that is lost. A second request arrives while the mask is set, which tells a correct mask apart from a mask that is only sampled at entry. The return registers are pushed and overwritten between two nested entries, which shows that the pulls really replace the captured state and that the return uses the pulled values. A return strobe that coincides with a boundary interrupt distinguishes the interrupt-wins ordering from one where the return target is lost.

// File: rtl/shpc_pkg.sv
package shpc_pkg;
  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_RET    = 4'd1,
    OP_PSH_PC = 4'd2,
    OP_PSH_FL = 4'd3,
    OP_PUL_PC = 4'd4,
    OP_PUL_FL = 4'd5,
    OP_LD_HND = 4'd6,
    OP_IEN    = 4'd7,
    OP_IDIS   = 4'd8,
    OP_UNMASK = 4'd9
  } op_e;
endpackage

// File: rtl/shpc_gate.sv
module shpc_gate
  import shpc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic irq_i,
  input  logic step_i,
  input  op_e  op_i,
  output logic take_o,
  output logic ack_o
);
  logic ie_q, mask_q, pend_q;

  assign take_o = step_i && (pend_q || irq_i) && ie_q && !mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      mask_q <= 1'b0;
      pend_q <= 1'b0;
      ack_o  <= 1'b0;
    end else begin
      ack_o  <= take_o;
      pend_q <= (pend_q || irq_i) && !take_o;
      if (op_i == OP_IEN)       ie_q <= 1'b1;
      else if (op_i == OP_IDIS) ie_q <= 1'b0;
      if (take_o)
        mask_q <= 1'b1;
      else if (op_i == OP_RET || op_i == OP_UNMASK)
        mask_q <= 1'b0;
    end
  end

  // R7: a pending request not taken stays pending
  assert_pending_held_R7: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !take_o) |=> pend_q);
  // R7: entry leaves the mask set
  assert_mask_on_entry_R7: assert property (@(posedge clk) disable iff (rst)
    take_o |=> mask_q);
endmodule

// File: rtl/shpc_regs.sv
module shpc_regs
  import shpc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op_i,
  input  logic [PC_W-1:0]   data_i,
  input  logic              take_i,
  input  logic [PC_W-1:0]   seq_pc_i,
  input  logic [FLAG_W-1:0] flags_live_i,
  output logic [PC_W-1:0]   hnd_o,
  output logic [PC_W-1:0]   rpc_o,
  output logic [FLAG_W-1:0] rfl_o,
  output logic [PC_W-1:0]   push_o
);
  localparam int PAD_W = PC_W - FLAG_W;
  logic is_ret;
  assign is_ret = (op_i == OP_RET);

  always_ff @(posedge clk) begin
    if (rst) begin
      hnd_o  <= '0;
      rpc_o  <= '0;
      rfl_o  <= '0;
      push_o <= '0;
    end else begin
      if (op_i == OP_LD_HND) hnd_o <= data_i;
      if (take_i) begin
        if (!is_ret) begin
          rpc_o <= seq_pc_i;
          rfl_o <= flags_live_i;
        end
      end else begin
        if (op_i == OP_PUL_PC) rpc_o <= data_i;
        if (op_i == OP_PUL_FL) rfl_o <= data_i[FLAG_W-1:0];
      end
      if (op_i == OP_PSH_PC)      push_o <= rpc_o;
      else if (op_i == OP_PSH_FL) push_o <= {{PAD_W{1'b0}}, rfl_o};
    end
  end

  // R9: entry coinciding with a return keeps the return target
  assert_ret_target_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (take_i && is_ret) |=> $stable(rpc_o));
endmodule

// File: rtl/shpc_pcf.sv
module shpc_pcf
  import shpc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic [PC_W-1:0]   seq_pc_i,
  input  op_e               op_i,
  input  logic              take_i,
  input  logic [PC_W-1:0]   hnd_i,
  input  logic [PC_W-1:0]   rpc_i,
  input  logic [FLAG_W-1:0] rfl_i,
  input  logic              flags_wr_i,
  input  logic [FLAG_W-1:0] flags_d_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic is_ret;
  assign is_ret = (op_i == OP_RET);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o    <= '0;
      flags_o <= '0;
    end else begin
      if (take_i)      pc_o <= hnd_i;
      else if (is_ret) pc_o <= rpc_i;
      else if (step_i) pc_o <= seq_pc_i;
      if (is_ret)          flags_o <= rfl_i;
      else if (flags_wr_i) flags_o <= flags_d_i;
    end
  end

  // R6: a plain return restores both PC and flags
  assert_ret_restores_R6: assert property (@(posedge clk) disable iff (rst)
    (is_ret && !take_i) |=> (pc_o == $past(rpc_i)) && (flags_o == $past(rfl_i)));
endmodule

// File: rtl/shpc_top.sv
module shpc_top
  import shpc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic [PC_W-1:0]   seq_pc_i,
  input  logic [3:0]        op_i,
  input  logic [PC_W-1:0]   data_i,
  input  logic              flags_wr_i,
  input  logic [FLAG_W-1:0] flags_d_i,
  input  logic              irq_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [PC_W-1:0]   push_o,
  output logic              ack_o
);
  op_e               op;
  logic              take;
  logic [PC_W-1:0]   hnd, rpc;
  logic [FLAG_W-1:0] rfl, flags_live;

  assign op         = op_e'(op_i);
  assign flags_live = flags_wr_i ? flags_d_i : flags_o;

  shpc_gate u_gate (
    .clk(clk), .rst(rst), .irq_i(irq_i), .step_i(step_i), .op_i(op),
    .take_o(take), .ack_o(ack_o)
  );

  shpc_regs #(.PC_W(PC_W), .FLAG_W(FLAG_W)) u_regs (
    .clk(clk), .rst(rst), .op_i(op), .data_i(data_i), .take_i(take),
    .seq_pc_i(seq_pc_i), .flags_live_i(flags_live),
    .hnd_o(hnd), .rpc_o(rpc), .rfl_o(rfl), .push_o(push_o)
  );

  shpc_pcf #(.PC_W(PC_W), .FLAG_W(FLAG_W)) u_pcf (
    .clk(clk), .rst(rst), .step_i(step_i), .seq_pc_i(seq_pc_i), .op_i(op),
    .take_i(take), .hnd_i(hnd), .rpc_i(rpc), .rfl_i(rfl),
    .flags_wr_i(flags_wr_i), .flags_d_i(flags_d_i),
    .pc_o(pc_o), .flags_o(flags_o)
  );

  // R2: acknowledge comes with the PC at the handler address
  assert_entry_pc_R2: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (pc_o == $past(hnd)));
  // R2: acknowledge lasts a single cycle
  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);
endmodule

// File: tb/sim_shpc_top.sv
module sim_shpc_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        step;
  logic [15:0] seq_pc, data;
  logic [3:0]  op;
  logic        fw, irq;
  logic [7:0]  fd;
  logic [15:0] pc, push;
  logic [7:0]  flags;
  logic        ack;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  shpc_top u0 (
    .clk(clk), .rst(rst), .step_i(step), .seq_pc_i(seq_pc), .op_i(op),
    .data_i(data), .flags_wr_i(fw), .flags_d_i(fd), .irq_i(irq),
    .pc_o(pc), .flags_o(flags), .push_o(push), .ack_o(ack)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic        step;
    logic        irq;
    logic [15:0] seq;
    logic [15:0] dat;
    logic        fw;
    logic [7:0]  fd;
    logic [15:0] epc;
    logic [7:0]  efl;
    logic        eack;
    logic [15:0] epush;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    // op  st  irq  seq       data      fw   fd      pc        fl      ack  push     req
    '{4'd6, 1'b1, 1'b0, 16'h0010, 16'h4000, 1'b0, 8'h00, 16'h0010, 8'h00, 1'b0, 16'h0000, 4'd4},  // R4 load handler, R10 step
    '{4'd0, 1'b1, 1'b1, 16'h0012, 16'h0000, 1'b1, 8'h5A, 16'h0012, 8'h5A, 1'b0, 16'h0000, 4'd8},  // R8 disabled, R11
    '{4'd7, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 8'h00, 16'h0012, 8'h5A, 1'b0, 16'h0000, 4'd10}, // R10 hold, enable
    '{4'd0, 1'b1, 1'b0, 16'h0014, 16'h0000, 1'b1, 8'h33, 16'h4000, 8'h33, 1'b1, 16'h0000, 4'd2},  // R2 take held request
    '{4'd2, 1'b1, 1'b0, 16'h4001, 16'h0000, 1'b0, 8'h00, 16'h4001, 8'h33, 1'b0, 16'h0014, 4'd3},  // R3 captured PC
    '{4'd3, 1'b1, 1'b1, 16'h4002, 16'h0000, 1'b0, 8'h00, 16'h4002, 8'h33, 1'b0, 16'h0033, 4'd3},  // R3 captured flags
    '{4'd0, 1'b1, 1'b0, 16'h4003, 16'h0000, 1'b1, 8'h0F, 16'h4003, 8'h0F, 1'b0, 16'h0033, 4'd7},  // R7 masked
    '{4'd9, 1'b1, 1'b0, 16'h4004, 16'h0000, 1'b0, 8'h00, 16'h4004, 8'h0F, 1'b0, 16'h0033, 4'd7},  // R7 unmask cycle
    '{4'd0, 1'b1, 1'b0, 16'h4005, 16'h0000, 1'b0, 8'h00, 16'h4000, 8'h0F, 1'b1, 16'h0033, 4'd7},  // R7 nested entry
    '{4'd2, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 8'h00, 16'h4000, 8'h0F, 1'b0, 16'h4005, 4'd5},  // R5 push PC
    '{4'd4, 1'b0, 1'b0, 16'h0000, 16'h0014, 1'b0, 8'h00, 16'h4000, 8'h0F, 1'b0, 16'h4005, 4'd5},  // R5 pull PC
    '{4'd5, 1'b0, 1'b0, 16'h0000, 16'h0033, 1'b0, 8'h00, 16'h4000, 8'h0F, 1'b0, 16'h4005, 4'd5},  // R5 pull flags
    '{4'd1, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 8'h00, 16'h0014, 8'h33, 1'b0, 16'h4005, 4'd6},  // R6 return
    '{4'd0, 1'b1, 1'b0, 16'h0016, 16'h0000, 1'b0, 8'h00, 16'h0016, 8'h33, 1'b0, 16'h4005, 4'd10}  // R10 step
  };

  task automatic drive(input logic [3:0] o, input logic s, input logic i,
                       input logic [15:0] sq, input logic [15:0] d,
                       input logic w, input logic [7:0] f);
    @(negedge clk);
    op = o; step = s; irq = i; seq_pc = sq; data = d; fw = w; fd = f;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; op = 4'd0; step = 1'b0; irq = 1'b0; seq_pc = '0; data = '0; fw = 1'b0; fd = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1", {pc, flags, ack, push}, {16'h0, 8'h0, 1'b0, 16'h0});
    @(negedge clk); rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      drive(TBL[k].op, TBL[k].step, TBL[k].irq, TBL[k].seq, TBL[k].dat, TBL[k].fw, TBL[k].fd);
      chk($sformatf("R%0d row%0d", TBL[k].req, k), {pc, flags, ack, push},
          {TBL[k].epc, TBL[k].efl, TBL[k].eack, TBL[k].epush});
    end

    // R9: interrupt and return in the same cycle
    drive(4'd4, 1'b0, 1'b0, 16'h0, 16'h0100, 1'b0, 8'h0);
    drive(4'd5, 1'b0, 1'b1, 16'h0, 16'h0011, 1'b0, 8'h0);
    drive(4'd1, 1'b1, 1'b0, 16'h0777, 16'h0, 1'b0, 8'h0);
    chk("R9 entry wins", {pc, flags, ack}, {16'h4000, 8'h11, 1'b1});
    drive(4'd2, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'h0);
    chk("R9 target kept", push, 16'h0100);
    drive(4'd3, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'h0);
    chk("R9 flags kept", push, 16'h0011);
    drive(4'd1, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'h0);
    chk("R6 return after R9", {pc, flags}, {16'h0100, 8'h11});

    // R8: disable blocks, request held until re-enable
    drive(4'd8, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0, 8'h0);
    drive(4'd0, 1'b1, 1'b0, 16'h0200, 16'h0, 1'b0, 8'h0);
    chk("R8 disabled no entry", {pc, ack}, {16'h0200, 1'b0});
    // R4: new handler address
    drive(4'd6, 1'b0, 1'b0, 16'h0, 16'h2222, 1'b0, 8'h0);
    drive(4'd7, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'h0);
    chk("R8 enable alone no entry", {pc, ack}, {16'h0200, 1'b0});
    drive(4'd0, 1'b1, 1'b0, 16'h0202, 16'h0, 1'b0, 8'h0);
    chk("R4 R8 held request taken at new handler", {pc, ack}, {16'h2222, 1'b1});
    drive(4'd0, 1'b1, 1'b0, 16'h2224, 16'h0, 1'b0, 8'h0);
    chk("R2 ack one cycle", {pc, ack}, {16'h2224, 1'b0});
    drive(4'd2, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 8'h0);
    chk("R3 return PC from last entry", push, 16'h0202);
    // R11: flag write loses to return in the same cycle
    drive(4'd1, 1'b0, 1'b0, 16'h0, 16'h0, 1'b1, 8'hEE);
    chk("R11 return beats flag write", {pc, flags}, {16'h0202, 8'h11});

    // R1: reset again mid-run clears outputs
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    chk("R1 reset again", {pc, flags, ack, push}, {16'h0, 8'h0, 1'b0, 16'h0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule